// File: doc/BRIEF.md
# Receive Character Queue with Error Lock

This block sits between a serial character receiver and the host or DMA side that drains received bytes. It holds a short queue of characters, each stored together with three error flags: parity error, receiver overrun and framing error. The reader sees the oldest character and its flags at once. A DMA request goes out whenever a character is waiting and the queue is not locked.

A two-bit mode selects how received characters raise the interrupt. In two of the modes, a character with a special condition locks the queue once software or DMA has read it. The lock holds the DMA request low and keeps further characters in place. The flags of the offending character stay latched so the service routine can inspect them. A one-cycle error-reset strobe then releases the lock, and normal traffic resumes with the next queued character.

When a character arrives while the queue is full, it replaces the newest entry, and that entry is marked with an overrun. Parity errors can be kept out of the special-condition set by a control bit. Overrun and framing errors always count as special conditions.

Top module: `rxq_errlock`

## Requirements
- R1: The queue holds up to 3 characters. They are read out in arrival order, each with the parity and framing flags it was written with. `rd_valid` is high exactly when at least one character is waiting, and a read pulse with `rd_valid` low has no effect.
- R2: A write while 3 characters are held, with no read in the same cycle, replaces the newest entry with the new character and sets that entry's overrun flag. The older entries are unchanged and the occupancy stays at 3.
- R3: A character has a special condition when its overrun or framing flag is set. A parity flag also counts when `par_special` is 1. When `par_special` is 0, a parity-only character is treated as clean.
- R4: With `irq_mode` = 2 (every character), `irq` is high whenever a character is waiting, flagged or not, and the queue never locks.
- R5: With `irq_mode` = 3 (special only), no interrupt is raised for a waiting character. Reading a special character raises `irq` in the following cycle.
- R6: With `irq_mode` = 1 (first character), `irq` is high while a character is waiting after the mode was entered or after an error reset, until one character is read. Later clean characters raise no interrupt. A special character raises `irq` only after it has been read.
- R7: In modes 1 and 3, reading a special character locks the queue. While locked, `dma_req` is low and read pulses are ignored: the waiting character stays at the head.
- R8: `err_stat` latches the flags of the character that caused the lock as {parity, overrun, framing} in bits 2..0. It holds that value until the error reset, and is 0 otherwise.
- R9: A one-cycle `err_reset` clears the lock, the pending special interrupt and `err_stat`. DMA requests resume for the next waiting character.
- R10: With `irq_mode` = 0 (interrupts off), `irq` stays low and the queue never locks.
- R11: `dma_req` is high exactly when a character is waiting and the queue is not locked. After reset the queue is empty, and `dma_req`, `irq` and `err_stat` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Receiver delivers a character |
| wr_data | input | 8 | Received character |
| wr_par_err | input | 1 | Parity error for the delivered character |
| wr_frm_err | input | 1 | Framing error for the delivered character |
| rd_en | input | 1 | Read (pop) the head character |
| rd_valid | output | 1 | A character is waiting |
| rd_data | output | 8 | Head character |
| rd_par_err | output | 1 | Head character parity flag |
| rd_ovr_err | output | 1 | Head character overrun flag |
| rd_frm_err | output | 1 | Head character framing flag |
| irq_mode | input | 2 | 0 off, 1 first character, 2 every character, 3 special only |
| par_special | input | 1 | Parity error counts as a special condition |
| err_reset | input | 1 | One-cycle error reset command |
| err_stat | output | 3 | Latched flags {parity, overrun, framing} of the locking character |
| dma_req | output | 1 | DMA transfer request |
| irq | output | 1 | Receive interrupt |

## Verification
The bench pushes a character into a full queue and checks that the newest slot, not the oldest, takes it with an overrun mark. A design that dropped the character or overwrote the head would return the wrong byte or flag on the third read. It locks the queue with parity, framing and overrun characters in turn and then tries to read past the lock. A design that let the read through, or raised `irq` before the flagged byte was read, would show a changed head or an early interrupt. It also checks that parity is masked when `par_special` is 0, that the queue never locks in modes 0 and 2, and that first-character mode re-arms after an error reset. A missing re-arm would leave `irq` low with a character waiting.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int RXQ_DW = 8;

    typedef struct packed {
        logic [RXQ_DW-1:0] data;
        logic              par;
        logic              ovr;
        logic              frm;
    } rxq_ent_t;

    typedef enum logic [1:0] {
        RXQ_IRQ_OFF   = 2'd0,
        RXQ_IRQ_FIRST = 2'd1,
        RXQ_IRQ_ALL   = 2'd2,
        RXQ_IRQ_SPEC  = 2'd3
    } rxq_mode_e;

    function automatic logic rxq_is_special(rxq_ent_t e, logic par_en);
        return e.ovr | e.frm | (e.par & par_en);
    endfunction

    function automatic logic rxq_mode_locks(rxq_mode_e m);
        return (m == RXQ_IRQ_FIRST) || (m == RXQ_IRQ_SPEC);
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     push,
    input  rxq_ent_t push_ent,
    input  logic     pop,
    output rxq_ent_t head,
    output logic     empty,
    output logic     full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    rxq_ent_t        mem [DEPTH];
    logic [PW-1:0]   wptr, rptr, last;
    logic [CW-1:0]   count;
    logic            do_pop, do_push, do_ovw;

    function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign empty   = (count == '0);
    assign full    = (count == CW'(DEPTH));
    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign do_ovw  = push && full && !do_pop;
    assign last    = (wptr == '0) ? PW'(DEPTH - 1) : wptr - PW'(1);
    assign head    = mem[rptr];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst) begin
                mem[i] <= '0;
            end else if (do_push && wptr == PW'(i)) begin
                mem[i] <= push_ent;
            end else if (do_ovw && last == PW'(i)) begin
                mem[i]     <= push_ent;
                mem[i].ovr <= 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= bump(wptr);
            if (do_pop)  rptr <= bump(rptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end

    // R1: occupancy never exceeds the depth
    a_r1_count_bound: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    // R2: a write into a full queue keeps it full
    a_r2_ovw_stays_full: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> full);

    // R2: the overwritten slot carries the overrun flag
    a_r2_ovw_flag: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> mem[$past(last)].ovr);

endmodule

// File: rtl/rxq_irq_ctl.sv
module rxq_irq_ctl
    import rxq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  rxq_mode_e mode,
    input  logic      par_special,
    input  logic      err_reset,
    input  logic      pop_fire,
    input  rxq_ent_t  head,
    input  logic      empty,
    output logic      locked,
    output logic      irq,
    output logic [2:0] err_stat
);
    rxq_mode_e mode_q;
    logic      armed, sc_pend, lock_evt, char_irq;

    assign lock_evt = pop_fire && rxq_is_special(head, par_special)
                      && rxq_mode_locks(mode);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q   <= RXQ_IRQ_OFF;
            armed    <= 1'b0;
            locked   <= 1'b0;
            sc_pend  <= 1'b0;
            err_stat <= '0;
        end else begin
            mode_q <= mode;
            if (lock_evt) begin
                locked   <= 1'b1;
                sc_pend  <= 1'b1;
                err_stat <= {head.par, head.ovr, head.frm};
            end else if (err_reset) begin
                locked   <= 1'b0;
                sc_pend  <= 1'b0;
                err_stat <= '0;
            end
            if ((mode == RXQ_IRQ_FIRST && mode_q != RXQ_IRQ_FIRST) || err_reset)
                armed <= 1'b1;
            else if (pop_fire)
                armed <= 1'b0;
        end
    end

    always_comb begin
        case (mode)
            RXQ_IRQ_ALL:   char_irq = !empty;
            RXQ_IRQ_FIRST: char_irq = armed && !empty && !locked;
            default:       char_irq = 1'b0;
        endcase
    end

    assign irq = (mode != RXQ_IRQ_OFF) && (char_irq || sc_pend);

    // R8: latched status holds while locked
    a_r8_stat_hold: assert property (@(posedge clk) disable iff (rst)
        (locked && !err_reset) |=> $stable(err_stat));

    // R9: error reset releases the lock
    a_r9_reset_unlocks: assert property (@(posedge clk) disable iff (rst)
        (err_reset && !lock_evt) |=> !locked);

    // R4: every-character mode never creates a lock
    a_r4_all_no_lock: assert property (@(posedge clk) disable iff (rst)
        (mode == RXQ_IRQ_ALL && !locked) |=> !locked);

    // R10: interrupts off means no interrupt
    a_r10_off_quiet: assert property (@(posedge clk) disable iff (rst)
        (mode == RXQ_IRQ_OFF) |-> !irq);

endmodule

// File: rtl/rxq_errlock.sv
module rxq_errlock
    import rxq_pkg::*;
#(
    parameter int DEPTH = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [RXQ_DW-1:0] wr_data,
    input  logic              wr_par_err,
    input  logic              wr_frm_err,
    input  logic              rd_en,
    output logic              rd_valid,
    output logic [RXQ_DW-1:0] rd_data,
    output logic              rd_par_err,
    output logic              rd_ovr_err,
    output logic              rd_frm_err,
    input  logic [1:0]        irq_mode,
    input  logic              par_special,
    input  logic              err_reset,
    output logic [2:0]        err_stat,
    output logic              dma_req,
    output logic              irq
);
    rxq_ent_t  in_ent, head;
    logic      empty, full, locked, pop_fire;
    rxq_mode_e mode;

    assign mode     = rxq_mode_e'(irq_mode);
    assign in_ent   = '{data: wr_data, par: wr_par_err, ovr: 1'b0, frm: wr_frm_err};
    assign pop_fire = rd_en && !empty && !locked;

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst      (rst),
        .push     (wr_en),
        .push_ent (in_ent),
        .pop      (pop_fire),
        .head     (head),
        .empty    (empty),
        .full     (full)
    );

    rxq_irq_ctl u_ctl (
        .clk         (clk),
        .rst         (rst),
        .mode        (mode),
        .par_special (par_special),
        .err_reset   (err_reset),
        .pop_fire    (pop_fire),
        .head        (head),
        .empty       (empty),
        .locked      (locked),
        .irq         (irq),
        .err_stat    (err_stat)
    );

    assign rd_valid   = !empty;
    assign rd_data    = head.data;
    assign rd_par_err = head.par;
    assign rd_ovr_err = head.ovr;
    assign rd_frm_err = head.frm;
    assign dma_req    = !empty && !locked;

    // R7: the head character is held while locked
    a_r7_head_held: assert property (@(posedge clk) disable iff (rst)
        (locked && !empty && !err_reset) |=> $stable(head));

    // R11: no DMA request while locked
    a_r11_no_dma_locked: assert property (@(posedge clk) disable iff (rst)
        locked |-> !dma_req);

    // R11: a full queue always requests DMA unless locked
    a_r11_full_requests: assert property (@(posedge clk) disable iff (rst)
        (full && !locked) |-> dma_req);

endmodule

// File: tb/sim_rxq_errlock.sv
module sim_rxq_errlock;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0, wr_par_err = 1'b0, wr_frm_err = 1'b0;
    logic [7:0] wr_data = '0;
    logic       rd_en = 1'b0;
    logic       rd_valid, rd_par_err, rd_ovr_err, rd_frm_err;
    logic [7:0] rd_data;
    logic [1:0] irq_mode = 2'd0;
    logic       par_special = 1'b1;
    logic       err_reset = 1'b0;
    logic [2:0] err_stat;
    logic       dma_req, irq;
    int         checks = 0, errors = 0;
    bit         done = 0;

    always #5 clk = ~clk;

    rxq_errlock u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .wr_par_err(wr_par_err), .wr_frm_err(wr_frm_err), .rd_en(rd_en),
        .rd_valid(rd_valid), .rd_data(rd_data), .rd_par_err(rd_par_err),
        .rd_ovr_err(rd_ovr_err), .rd_frm_err(rd_frm_err), .irq_mode(irq_mode),
        .par_special(par_special), .err_reset(err_reset), .err_stat(err_stat),
        .dma_req(dma_req), .irq(irq)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic push(logic [7:0] d, logic p, logic f);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d; wr_par_err = p; wr_frm_err = f;
        @(negedge clk);
        wr_en = 1'b0; wr_par_err = 1'b0; wr_frm_err = 1'b0;
    endtask

    task automatic pop();
        @(negedge clk); rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic clr();
        @(negedge clk); err_reset = 1'b1;
        @(negedge clk); err_reset = 1'b0;
    endtask

    task automatic read_chk(string req, logic [7:0] d, logic p, logic o, logic f);
        chk({req, " valid"}, rd_valid, 1);
        chk({req, " data"}, rd_data, d);
        chk({req, " flags"}, {rd_par_err, rd_ovr_err, rd_frm_err}, {p, o, f});
        pop();
    endtask

    task automatic t_reset();
        chk("R11 reset valid", rd_valid, 0);
        chk("R11 reset dma", dma_req, 0);
        chk("R11 reset irq", irq, 0);
        chk("R11 reset stat", err_stat, 0);
    endtask

    task automatic t_order();
        irq_mode = 2'd0;
        push(8'hA1, 1'b0, 1'b0);
        push(8'hB2, 1'b1, 1'b0);
        push(8'hC3, 1'b0, 1'b1);
        chk("R11 dma with data", dma_req, 1);
        chk("R10 off no irq", irq, 0);
        read_chk("R1 first", 8'hA1, 0, 0, 0);
        read_chk("R1 second", 8'hB2, 1, 0, 0);
        chk("R10 off no lock", dma_req, 1);
        read_chk("R1 third", 8'hC3, 0, 0, 1);
        chk("R1 empty", rd_valid, 0);
        pop();
        chk("R1 empty read ignored", rd_valid, 0);
        chk("R10 off stat", err_stat, 0);
    endtask

    task automatic t_overrun();
        irq_mode = 2'd0;
        push(8'h10, 1'b0, 1'b0);
        push(8'h11, 1'b0, 1'b0);
        push(8'h12, 1'b0, 1'b0);
        push(8'h44, 1'b0, 1'b0);
        read_chk("R2 oldest kept", 8'h10, 0, 0, 0);
        read_chk("R2 middle kept", 8'h11, 0, 0, 0);
        read_chk("R2 newest replaced", 8'h44, 0, 1, 0);
        chk("R2 occupancy 3", rd_valid, 0);
    endtask

    task automatic t_all();
        irq_mode = 2'd2;
        push(8'h20, 1'b0, 1'b0);
        chk("R4 irq clean", irq, 1);
        pop();
        chk("R4 irq drops when empty", irq, 0);
        push(8'h21, 1'b0, 1'b1);
        chk("R4 irq flagged", irq, 1);
        pop();
        push(8'h22, 1'b0, 1'b0);
        chk("R4 no lock dma", dma_req, 1);
        chk("R4 no lock stat", err_stat, 0);
        pop();
    endtask

    task automatic t_spec();
        irq_mode = 2'd3; par_special = 1'b1;
        push(8'h30, 1'b1, 1'b0);
        chk("R5 no irq before read", irq, 0);
        chk("R11 dma before read", dma_req, 1);
        pop();
        chk("R5 irq after read", irq, 1);
        push(8'h31, 1'b0, 1'b0);
        chk("R7 dma held low", dma_req, 0);
        pop();
        chk("R7 read ignored valid", rd_valid, 1);
        chk("R7 read ignored head", rd_data, 8'h31);
        chk("R8 stat parity", err_stat, 3'b100);
        clr();
        chk("R9 irq cleared", irq, 0);
        chk("R9 dma resumes", dma_req, 1);
        chk("R9 stat cleared", err_stat, 0);
        read_chk("R9 next entry", 8'h31, 0, 0, 0);
        chk("R5 clean no irq", irq, 0);
    endtask

    task automatic t_mask();
        irq_mode = 2'd3; par_special = 1'b0;
        push(8'h40, 1'b1, 1'b0);
        pop();
        chk("R3 parity masked irq", irq, 0);
        push(8'h41, 1'b0, 1'b0);
        chk("R3 parity masked dma", dma_req, 1);
        pop();
        push(8'h42, 1'b0, 1'b1);
        pop();
        chk("R3 framing counts", irq, 1);
        chk("R8 stat framing", err_stat, 3'b001);
        clr();
        push(8'h60, 1'b0, 1'b0);
        push(8'h61, 1'b0, 1'b0);
        push(8'h62, 1'b0, 1'b0);
        push(8'h63, 1'b0, 1'b0);
        read_chk("R3 ovr a", 8'h60, 0, 0, 0);
        read_chk("R3 ovr b", 8'h61, 0, 0, 0);
        chk("R3 no irq yet", irq, 0);
        read_chk("R3 ovr c", 8'h63, 0, 1, 0);
        chk("R3 overrun counts", irq, 1);
        chk("R8 stat overrun", err_stat, 3'b010);
        clr();
        par_special = 1'b1;
    endtask

    task automatic t_first();
        @(negedge clk); irq_mode = 2'd1;
        @(negedge clk);
        push(8'h50, 1'b0, 1'b0);
        chk("R6 first irq", irq, 1);
        pop();
        chk("R6 irq after read", irq, 0);
        push(8'h51, 1'b0, 1'b0);
        chk("R6 later clean no irq", irq, 0);
        pop();
        push(8'h52, 1'b0, 1'b1);
        chk("R6 special not before read", irq, 0);
        pop();
        chk("R6 special after read", irq, 1);
        chk("R8 stat first mode", err_stat, 3'b001);
        push(8'h53, 1'b0, 1'b0);
        chk("R7 first mode lock", dma_req, 0);
        clr();
        chk("R9 rearm irq", irq, 1);
        chk("R9 rearm dma", dma_req, 1);
        pop();
        chk("R6 rearm cleared", irq, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_order();
        t_overrun();
        t_all();
        t_spec();
        t_mask();
        t_first();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule